// File: doc/BRIEF.md
# Serialized interrupt line device agent

This block is the device end of a one-wire serialized interrupt bus. One open-drain line is shared by a host controller and several devices. The host opens each bus cycle with a long low pulse, the Start Frame. A run of three-clock data frames follows, and a short low pulse, the Stop Frame, closes the cycle. The agent is given a slot number and a local request level. It follows the Start and Stop Frames to keep its place in the slot timing. In its own slot it reports the request level, and in quiet mode it opens a bus cycle itself when the level has changed since it last reported it.

The agent watches the line through `line_in` and drives it through `line_oe` and `line_out`. It has five states. In IDLE it waits between cycles. It moves IDLE to KICK when quiet mode is active, the request differs from the last reported value and the line is high. KICK always moves to WAIT after one clock. WAIT holds until the host recognisably starts a cycle. A recognised Start Frame moves any state to FRAMES. FRAMES moves to GAP when a Stop Frame ends, and GAP always moves to IDLE one clock later. The GAP clock is the hold-off that keeps a self-started frame at least two clocks clear of the Stop Frame.

Top module: `ser_irq_agent`

## Requirements
- R1: During reset and after it, `line_oe` is 0 and the agent is in continuous mode. With `irq_level`=1 (different from the reset reported value 0) it drives nothing until a Stop Frame selects quiet mode.
- R2: Number the clocks from the first high sample after a Start Frame (clock 0). For a valid slot n with `irq_level`=1 at that time, the agent drives low in clock 3n-1, drives high in clock 3n and releases the line from clock 3n+1.
- R3: With `irq_level`=0 at its slot time, the agent does not drive the line at all during the frames.
- R4: A `slot_sel` of 0, 1 or above 16 is invalid. The agent then never drives the line and never opens a cycle.
- R5: With `slot_sel`=3 and `smi_shared`=1 the agent never drives. With `smi_shared`=0, slot 3 behaves like any valid slot.
- R6: A Start Frame is a low run of at least 4 clocks. A 1-clock low inside the frames, or a 3-clock low while idle, does not restart or open slot timing.
- R7: A low run of 2 clocks ending after a Start Frame selects quiet mode, and a run of 3 clocks selects continuous mode. A 2-clock low while idle changes neither.
- R8: In quiet mode, a start pulse is exactly one clock low. If a change is already pending when the Stop Frame ends, the pulse falls in clock 3 counted from the Stop Frame's first high sample. If the level changes while idle, the pulse falls in the clock after the edge that samples the change.
- R9: In continuous mode the agent never begins a cycle, even with a pending change.
- R10: After its start pulse, the agent does not pulse again until the host completes a Start Frame.
- R11: The change test compares against the value reported in the agent's last own slot. If `irq_level` equals that value, no start pulse is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_sel | input | 5 | Assigned slot number, valid 2 to 16 |
| smi_shared | input | 1 | Slot 3 is reserved for the management interrupt; refuse to use it |
| irq_level | input | 1 | Local request level, 1 = asserted |
| line_in | input | 1 | Sampled level of the shared line |
| line_oe | output | 1 | Output enable for the shared line |
| line_out | output | 1 | Value driven while `line_oe` is 1 |

## Verification
The hardest situation to reach is a start pulse that is already pending when a Stop Frame ends. It needs quiet mode, a reported value, and a level change placed after the agent's slot but before the Stop Frame. The bench gets there by flipping the request at clock 50 of a frame sequence with slot 5, then closing with a 2-clock Stop Frame. It then checks the line clock by clock for a single low in clock 3. Short idle lows of 2 and 3 clocks are also injected, each while a pending change or a driven slot would expose a wrong decode.

// File: rtl/ser_irq_pkg.sv
package ser_irq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_KICK,
        ST_WAIT,
        ST_FRAMES,
        ST_GAP
    } agent_state_t;

endpackage

// File: rtl/line_low_meter.sv
module line_low_meter #(
    parameter int RUN_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_in,
    output logic [RUN_W-1:0] low_run,
    output logic             line_rise
);

    localparam logic [RUN_W-1:0] RUN_MAX = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run <= '0;
        end else if (line_in) begin
            low_run <= '0;
        end else if (low_run != RUN_MAX) begin
            low_run <= low_run + 1'b1;
        end
    end

    assign line_rise = line_in && (low_run != '0);

    // R6: every low sample leaves a nonzero run length behind it
    assert_low_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !line_in |=> (low_run != '0));

endmodule

// File: rtl/slot_decode.sv
module slot_decode #(
    parameter int SLOT_W   = 5,
    parameter int MAX_SLOT = 16,
    parameter int CNT_W    = 7
) (
    input  logic [SLOT_W-1:0] slot_sel,
    input  logic              smi_shared,
    output logic              slot_ok,
    output logic [CNT_W-1:0]  tgt_pos
);

    localparam logic [SLOT_W-1:0] SLOT_LO  = SLOT_W'(2);
    localparam logic [SLOT_W-1:0] SLOT_HI  = SLOT_W'(MAX_SLOT);
    localparam logic [SLOT_W-1:0] SLOT_SMI = SLOT_W'(3);

    always_comb begin
        slot_ok = (slot_sel >= SLOT_LO) && (slot_sel <= SLOT_HI)
                  && !((slot_sel == SLOT_SMI) && smi_shared);
        // drive is registered one clock ahead of sample clock 3n-1
        tgt_pos = CNT_W'(slot_sel) * CNT_W'(3) - CNT_W'(2);
    end

endmodule

// File: rtl/ser_irq_agent.sv
module ser_irq_agent
    import ser_irq_pkg::*;
#(
    parameter int SLOT_W    = 5,
    parameter int MAX_SLOT  = 16,
    parameter int START_MIN = 4,
    parameter int RUN_W     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SLOT_W-1:0] slot_sel,
    input  logic              smi_shared,
    input  logic              irq_level,
    input  logic              line_in,
    output logic              line_oe,
    output logic              line_out
);

    localparam int CNT_W = $clog2(3 * MAX_SLOT + 2) + 1;
    localparam logic [CNT_W-1:0] POS_MAX = '1;

    logic [RUN_W-1:0] low_run;
    logic             line_rise;
    logic             slot_ok;
    logic [CNT_W-1:0] tgt_pos;

    agent_state_t     state, nstate;
    logic [CNT_W-1:0] pos;
    logic             quiet_mode;
    logic             last_rep;
    logic             drove;

    logic start_end, stop_end, pending, slot_hit;

    line_low_meter #(.RUN_W(RUN_W)) u_meter (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_in   (line_in),
        .low_run   (low_run),
        .line_rise (line_rise)
    );

    slot_decode #(.SLOT_W(SLOT_W), .MAX_SLOT(MAX_SLOT), .CNT_W(CNT_W)) u_slot (
        .slot_sel   (slot_sel),
        .smi_shared (smi_shared),
        .slot_ok    (slot_ok),
        .tgt_pos    (tgt_pos)
    );

    always_comb begin
        start_end = line_rise && (low_run >= RUN_W'(START_MIN));
        stop_end  = (state == ST_FRAMES) && line_rise
                    && ((low_run == RUN_W'(2)) || (low_run == RUN_W'(3)));
        pending   = slot_ok && quiet_mode && (irq_level != last_rep);
        slot_hit  = (state == ST_FRAMES) && slot_ok && (pos == tgt_pos) && !start_end;
    end

    always_comb begin
        nstate = state;
        if (start_end) begin
            nstate = ST_FRAMES;
        end else begin
            unique case (state)
                ST_IDLE:   if (pending && line_in) nstate = ST_KICK;
                ST_KICK:   nstate = ST_WAIT;
                ST_WAIT:   nstate = ST_WAIT;
                ST_FRAMES: if (stop_end) nstate = ST_GAP;
                ST_GAP:    nstate = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            pos        <= POS_MAX;
            quiet_mode <= 1'b0;
            last_rep   <= 1'b0;
        end else begin
            state <= nstate;
            if (start_end) begin
                pos <= CNT_W'(1);
            end else if (pos != POS_MAX) begin
                pos <= pos + 1'b1;
            end
            if (stop_end) begin
                quiet_mode <= (low_run == RUN_W'(2));
            end
            if (slot_hit) begin
                last_rep <= irq_level;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_oe  <= 1'b0;
            line_out <= 1'b1;
            drove    <= 1'b0;
        end else if (start_end || stop_end) begin
            line_oe  <= 1'b0;
            line_out <= 1'b1;
            drove    <= 1'b0;
        end else if ((state == ST_IDLE) && (nstate == ST_KICK)) begin
            line_oe  <= 1'b1;
            line_out <= 1'b0;
        end else if (state == ST_KICK) begin
            line_oe  <= 1'b0;
            line_out <= 1'b1;
        end else if (slot_hit) begin
            if (irq_level) begin
                line_oe  <= 1'b1;
                line_out <= 1'b0;
                drove    <= 1'b1;
            end
        end else if (drove && !line_out) begin
            line_out <= 1'b1;
        end else if (drove) begin
            line_oe <= 1'b0;
            drove   <= 1'b0;
        end
    end

    // R2: a low slot drive only appears one count past the slot target
    assert_slot_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (line_oe && !line_out && (state == ST_FRAMES) && $stable(slot_sel))
        |-> (pos == tgt_pos + CNT_W'(1)));

    // R3: a slot sampled with the request low leaves the line alone
    assert_quiet_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_hit && !irq_level) |=> !line_oe);

    // R4 and R5: an unusable slot number never leads to driving
    assert_no_drive_invalid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!slot_ok, 1) && $past(!slot_ok, 2) && $past(!slot_ok, 3)) |-> !line_oe);

    // R7: the stop width decides the mode
    assert_stop_decode_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stop_end |=> (quiet_mode == ($past(low_run) == RUN_W'(2))));

    // R8: a self-started low lasts one clock
    assert_kick_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (line_oe && !line_out && (state == ST_KICK)) |=> !line_oe);

    // R9: outside the frames a low drive requires quiet mode
    assert_no_kick_cont_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (line_oe && !line_out && (state != ST_FRAMES)) |-> quiet_mode);

endmodule

// File: tb/sim_ser_irq_agent.sv
`timescale 1ns/100ps
module sim_ser_irq_agent;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] slot_sel = 5'd5;
    logic       smi_shared = 1'b0;
    logic       irq_level = 1'b1;
    logic       host_low = 1'b0;
    logic       dev_low = 1'b0;
    logic       line_oe, line_out;
    wire        bus_line;

    int vectors = 0;
    int misses = 0;

    always #2 clk = ~clk;

    assign bus_line = ~host_low & ~dev_low & (line_oe ? line_out : 1'b1);

    ser_irq_agent u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot_sel   (slot_sel),
        .smi_shared (smi_shared),
        .irq_level  (irq_level),
        .line_in    (bus_line),
        .line_oe    (line_oe),
        .line_out   (line_out)
    );

    task automatic step();
        @(negedge clk);
        #0.5;
    endtask

    task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s: {oe,line} actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic low_pulse(input int len);
        host_low = 1'b1;
        repeat (len) step();
        host_low = 1'b0;
        #0.5;
    endtask

    // watch n clocks of the line; kick_at = clock of an expected one-clock low
    task automatic idle_watch(input int n, input string req, input int kick_at);
        for (int k = 0; k < n; k++) begin
            #0.1;
            chk(req, {line_oe, bus_line}, (k == kick_at) ? 2'b10 : 2'b01);
            step();
            #0.5;
        end
    endtask

    task automatic run_cycle(input int n, input bit smi, input bit lvl,
                             input int flip_at, input int stopw);
        bit valid, drv;
        string req;
        slot_sel   = 5'(n);
        smi_shared = smi;
        irq_level  = lvl;
        valid = (n >= 2) && (n <= 16) && !((n == 3) && smi);
        drv   = valid && lvl;
        if (valid) req = lvl ? "R2" : "R3";
        else       req = ((n == 3) && smi) ? "R5" : "R4";
        low_pulse(4);
        for (int k = 0; k <= 52; k++) begin
            logic oe_e, ln_e;
            dev_low = (k == 2);           // another device's 1-clock slot low (R6)
            if (k == flip_at) irq_level = ~irq_level;
            #0.5;
            oe_e = drv && ((k == 3*n - 1) || (k == 3*n));
            ln_e = !((drv && (k == 3*n - 1)) || (k == 2));
            chk(req, {line_oe, bus_line}, {oe_e, ln_e});
            step();
        end
        dev_low = 1'b0;
        low_pulse(stopw);
    endtask

    initial begin
        repeat (3) step();
        chk("R1", {line_oe, bus_line}, 2'b01);
        repeat (2) step();
        rst_n = 1'b1;
        step();
        idle_watch(10, "R1", -1);

        // quiet mode, level equals reported value: no start pulse
        run_cycle(5, 0, 1, -1, 2);
        idle_watch(10, "R11", -1);

        // level changes while idle in quiet mode
        irq_level = 1'b0;
        step();
        #0.5;
        idle_watch(2, "R8", 0);
        idle_watch(10, "R10", -1);

        // change pending when the stop frame ends
        run_cycle(5, 0, 0, 50, 2);
        idle_watch(6, "R8", 3);

        // back to continuous mode, reported value 1
        run_cycle(5, 0, 1, -1, 3);
        irq_level = 1'b0;
        idle_watch(20, "R9", -1);

        // idle 2-clock low must not select quiet mode
        low_pulse(2);
        idle_watch(10, "R7", -1);

        // idle 3-clock low must not open slot timing
        irq_level = 1'b1;
        low_pulse(3);
        idle_watch(30, "R6", -1);

        // sweep all slot numbers, both levels, continuous mode
        for (int n = 0; n <= 32; n++) begin
            if (n > 18 && n != 31) continue;
            for (int s = 0; s <= ((n == 3) ? 1 : 0); s++) begin
                for (int l = 0; l <= 1; l++) begin
                    run_cycle(n, s[0], l[0], -1, 3);
                end
            end
        end

        // invalid slot in quiet mode with a changed level: no start pulse
        run_cycle(0, 0, 0, -1, 2);
        idle_watch(10, "R4", -1);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        misses++;
        $display("FAIL watchdog: run did not end, actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule